// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block decides how many wait states an external bus cycle receives. Each wait state is one clock of `clk`, which serves as the state clock, so every inserted wait lengthens the cycle by exactly one state time. A cycle begins when `cyc_start` is sampled high while the controller is idle. From then on, the controller raises `wait_en` for each state that is to be stretched. It then pulses `cyc_done` for one clock when the cycle may finish.

The wait count depends on several inputs. Until the boot configuration has been read (`cfg_done` low), the count is a fixed three. After that, a 3-bit ready-control field sets a cap of zero to three waits, or no cap at all. Within that cap, waiting goes on while the external READY line is low. Accesses to internal memory never wait. The READY line passes through a two-flop synchronizer. When the pin is not selected as the READY input, the internal ready value is held low. In unlimited mode this stalls the bus, and an optional watchdog ends such a stall after a set number of waits and flags a timeout.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, with no cycle started, `wait_en`, `cyc_done` and `wdog_tmo` are all 0.
- R2: An external cycle started with `cfg_done` low gets exactly 3 waits, whatever `rdy_pin` and `rdy_ctl` are.
- R3: A cycle started with `addr_internal` high gets 0 waits and `cyc_done` in the first clock after the start, under every `rdy_ctl`, `cfg_done` and READY level.
- R4: With `cfg_done` high and READY held low, `rdy_ctl` values 3'b000, 3'b001, 3'b010 and 3'b011 give 0, 1, 2 and 3 waits.
- R5: With `cfg_done` high and READY held low, `rdy_ctl` values 3'b100, 3'b101 and 3'b110 give 3 waits.
- R6: With `cfg_done` high, a high synchronized READY ends waiting. If READY rises just after the n-th wait is seen, the cycle ends after n+1 waits, because of the two-flop synchronizer.
- R7: `rdy_ctl` = 3'b111 sets unlimited mode: waits continue while READY stays low, and 0 waits occur if READY is already high.
- R8: When `rdy_pin_sel` is 0, the internal READY reads as 0 whatever the pin level. A capped setting then always reaches its cap, and unlimited mode waits until the watchdog ends the cycle.
- R9: With the watchdog enabled, an unlimited cycle whose READY stays low ends after exactly `WDOG_LIMIT` waits, and `wdog_tmo` is high in the same clock as `cyc_done`.
- R10: `cyc_done` is high for exactly one clock, in the clock right after the last wait. `wait_en` and `cyc_done` are never high together.
- R11: `cyc_start` is ignored while a cycle is in progress, and the wait count starts from zero for every new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock; one period is one wait state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Bus cycle start strobe, taken when idle |
| addr_internal | input | 1 | 1 = access targets internal memory |
| cfg_done | input | 1 | 1 = configuration bytes have been fetched |
| rdy_ctl | input | 3 | Ready-control field (cap 0..3, 3'b111 unlimited) |
| rdy_pin | input | 1 | Asynchronous external READY line |
| rdy_pin_sel | input | 1 | 1 = pin works as READY input, 0 = general port pin |
| wait_en | output | 1 | Current state is a wait state |
| cyc_done | output | 1 | One-clock bus cycle completion strobe |
| wdog_tmo | output | 1 | Unlimited wait ended by the watchdog |

## Verification
The bench targets the precedence among internal access, the boot default and the programmed cap. A design that let the boot default win over an internal access would stretch internal fetches to three waits, and one that read READY before configuration would end boot cycles early. The saturating codes 3'b100 to 3'b110 are checked, since a design that used only the low two bits would give 0 to 2 waits for them. A mid-cycle READY release checks the exact synchronizer latency, and an off-by-one shows up as one wait too many or too few. The port-pin case and the watchdog limit are checked together, so a design that passed the raw pin or never timed out either finishes too soon or hangs. A second start strobe sent during a busy cycle checks that no extra cycle is started.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_FIXED = 2'd1,
    MODE_CAP   = 2'd2,
    MODE_OPEN  = 2'd3
  } wait_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bwc_state_e;

  localparam logic [2:0] CTL_OPEN   = 3'b111;
  localparam logic [1:0] BOOT_WAITS = 2'd3;
  localparam logic [1:0] MAX_CAP    = 2'd3;

endpackage

// File: rtl/bwc_rdy_sync.sv
module bwc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pin_sel,
  output logic rdy_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              raw;

  // A port-pin configuration presents a constant "not ready"
  assign raw = pin & pin_sel;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = raw;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rdy_s = sync_q[STAGES-1];
endmodule

// File: rtl/bwc_limit_dec.sv
module bwc_limit_dec
  import bwc_pkg::*;
(
  input  logic       is_int,
  input  logic       cfg_done,
  input  logic [2:0] ctl,
  output wait_mode_e mode,
  output logic [1:0] lim
);
  always_comb begin
    mode = MODE_NONE;
    lim  = 2'd0;
    if (is_int) begin
      mode = MODE_NONE;
    end else if (!cfg_done) begin
      mode = MODE_FIXED;
      lim  = BOOT_WAITS;
    end else if (ctl == CTL_OPEN) begin
      mode = MODE_OPEN;
    end else begin
      mode = MODE_CAP;
      lim  = ctl[2] ? MAX_CAP : ctl[1:0];
    end
  end
endmodule

// File: rtl/bwc_wait_cnt.sv
module bwc_wait_cnt #(
  parameter int WDOG_EN    = 1,
  parameter int WDOG_LIMIT = 255,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wdog_hit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    if (clr)           cnt_d = '0;
    else if (&cnt_q)   cnt_d = cnt_q;
    else               cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (WDOG_EN != 0) begin : g_wdog
      assign wdog_hit = (cnt_q >= CNT_W'(WDOG_LIMIT));
    end else begin : g_nowdog
      assign wdog_hit = 1'b0;
    end
  endgenerate

  assign cnt = cnt_q;
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int WDOG_EN     = 1,
  parameter int WDOG_LIMIT  = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       addr_internal,
  input  logic       cfg_done,
  input  logic [2:0] rdy_ctl,
  input  logic       rdy_pin,
  input  logic       rdy_pin_sel,
  output logic       wait_en,
  output logic       cyc_done,
  output logic       wdog_tmo
);
  localparam int CNT_RAW = $clog2(WDOG_LIMIT + 1);
  localparam int CNT_W   = (CNT_RAW < 2) ? 2 : CNT_RAW;

  bwc_state_e       state_q, state_d;
  wait_mode_e       mode_q, mode_d, dec_mode;
  logic [1:0]       lim_q, lim_d, dec_lim;
  logic             rdy_s;
  logic             accept;
  logic             need_wait;
  logic             done_c;
  logic             tmo_c;
  logic [CNT_W-1:0] cnt;
  logic             wdog_hit;

  bwc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (rdy_pin),
    .pin_sel (rdy_pin_sel),
    .rdy_s   (rdy_s)
  );

  bwc_limit_dec u_dec (
    .is_int   (addr_internal),
    .cfg_done (cfg_done),
    .ctl      (rdy_ctl),
    .mode     (dec_mode),
    .lim      (dec_lim)
  );

  assign accept = (state_q == ST_IDLE) && cyc_start;

  bwc_wait_cnt #(
    .WDOG_EN    (WDOG_EN),
    .WDOG_LIMIT (WDOG_LIMIT),
    .CNT_W      (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .inc      (wait_en),
    .cnt      (cnt),
    .wdog_hit (wdog_hit)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    lim_d     = lim_q;
    need_wait = 1'b0;
    done_c    = 1'b0;
    tmo_c     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cyc_start) begin
          state_d = ST_BUSY;
          mode_d  = dec_mode;
          lim_d   = dec_lim;
        end
      end
      ST_BUSY: begin
        case (mode_q)
          MODE_FIXED: need_wait = (cnt < CNT_W'(BOOT_WAITS));
          MODE_CAP:   need_wait = !rdy_s && (cnt < CNT_W'(lim_q));
          MODE_OPEN: begin
            need_wait = !rdy_s && !wdog_hit;
            tmo_c     = !rdy_s && wdog_hit;
          end
          default:    need_wait = 1'b0;
        endcase
        if (!need_wait) begin
          done_c  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NONE;
      lim_q  <= 2'd0;
    end else if (accept) begin
      mode_q <= mode_d;
      lim_q  <= lim_d;
    end
  end

  assign wait_en  = (state_q == ST_BUSY) && need_wait;
  assign cyc_done = done_c;
  assign wdog_tmo = tmo_c;
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker
  import bwc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic             addr_internal,
  input bwc_state_e       state_q,
  input wait_mode_e       mode_q,
  input logic [CNT_W-1:0] cnt,
  input logic             wait_en,
  input logic             cyc_done,
  input logic             wdog_tmo
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R10
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_en && cyc_done)); // R10
  AST_INT_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cyc_start && addr_internal) |=> (cyc_done && !wait_en)); // R3
  AST_BOOT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && mode_q == MODE_FIXED) |-> (cnt == CNT_W'(3))); // R2
  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && mode_q == MODE_CAP) |-> (cnt < CNT_W'(3))); // R5
  AST_TMO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_tmo |-> cyc_done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!wait_en && !cyc_done)); // R11
endmodule

bind bus_wait_ctrl bwc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_start     (cyc_start),
  .addr_internal (addr_internal),
  .state_q       (state_q),
  .mode_q        (mode_q),
  .cnt           (cnt),
  .wait_en       (wait_en),
  .cyc_done      (cyc_done),
  .wdog_tmo      (wdog_tmo)
);

// File: tb/bus_wait_ctrl_tb_top.sv
module bus_wait_ctrl_tb_top;
  localparam int WDOG = 20;
  localparam int NV   = 16;

  logic       clk;
  logic       rst_n;
  logic       cyc_start;
  logic       addr_internal;
  logic       cfg_done;
  logic [2:0] rdy_ctl;
  logic       rdy_pin;
  logic       rdy_pin_sel;
  logic       wait_en;
  logic       cyc_done;
  logic       wdog_tmo;

  int n_run;
  int n_fail;

  bus_wait_ctrl #(.WDOG_EN(1), .WDOG_LIMIT(WDOG), .SYNC_STAGES(2)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_start     (cyc_start),
    .addr_internal (addr_internal),
    .cfg_done      (cfg_done),
    .rdy_ctl       (rdy_ctl),
    .rdy_pin       (rdy_pin),
    .rdy_pin_sel   (rdy_pin_sel),
    .wait_en       (wait_en),
    .cyc_done      (cyc_done),
    .wdog_tmo      (wdog_tmo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {int, cfg, sel, ctl[2:0], rdy, exp_waits[7:0], exp_tmo}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 3'b000, 1'b1, 8'd3,  1'b0},
    {1'b0, 1'b0, 1'b1, 3'b111, 1'b0, 8'd3,  1'b0},
    {1'b1, 1'b1, 1'b1, 3'b111, 1'b0, 8'd0,  1'b0},
    {1'b1, 1'b0, 1'b1, 3'b011, 1'b0, 8'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 8'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b001, 1'b0, 8'd1,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b010, 1'b0, 8'd2,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b011, 1'b0, 8'd3,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b100, 1'b0, 8'd3,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b110, 1'b0, 8'd3,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b011, 1'b1, 8'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 8'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 8'd20, 1'b1},
    {1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 8'd20, 1'b1},
    {1'b0, 1'b1, 1'b0, 3'b010, 1'b1, 8'd2,  1'b0},
    {1'b0, 1'b1, 1'b1, 3'b101, 1'b0, 8'd3,  1'b0}
  };
  string vtag [NV] = '{"R2", "R2", "R3", "R3", "R4", "R4", "R4", "R4",
                       "R5", "R5", "R6", "R7", "R9", "R8", "R8", "R5"};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runs one bus cycle; rel_after >= 0 raises rdy_pin after that many waits are seen
  task automatic run_cycle(input logic intl, input logic cfg, input logic sel,
                           input logic [2:0] ctl, input logic rdy, input int rel_after,
                           output int waits, output logic tmo, output logic seen,
                           output logic pulse_ok);
    waits = 0; tmo = 1'b0; seen = 1'b0; pulse_ok = 1'b0;
    @(negedge clk);
    addr_internal = intl; cfg_done = cfg; rdy_pin_sel = sel;
    rdy_ctl = ctl; rdy_pin = rdy;
    repeat (4) @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (cyc_done) begin
        seen = 1'b1;
        tmo  = wdog_tmo;
        break;
      end
      if (wait_en) begin
        waits++;
        if (waits == rel_after) rdy_pin = 1'b1;
      end
      @(negedge clk);
    end
    @(negedge clk);
    pulse_ok = !cyc_done;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int   w;
    logic t, s, p;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; cyc_start = 1'b0; addr_internal = 1'b0; cfg_done = 1'b0;
    rdy_ctl = 3'b000; rdy_pin = 1'b1; rdy_pin_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wait_en && !cyc_done && !wdog_tmo, "R1 in reset", int'({wait_en, cyc_done, wdog_tmo}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wait_en && !cyc_done && !wdog_tmo, "R1 after reset", int'({wait_en, cyc_done, wdog_tmo}), 0);

    for (int i = 0; i < NV; i++) begin
      run_cycle(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9], -1, w, t, s, p);
      chk(s, {vtag[i], " done seen"}, int'(s), 1);
      chk(w == int'(VEC[i][8:1]), {vtag[i], " waits"}, w, int'(VEC[i][8:1]));
      chk(t == VEC[i][0], {vtag[i], " timeout flag"}, int'(t), int'(VEC[i][0]));
      chk(p, "R10 done pulse width", int'(!p), 0);
    end

    // R6: unlimited, READY released after 5th wait -> 6 waits
    run_cycle(1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 5, w, t, s, p);
    chk(w == 6 && !t, "R6 open release", w, 6);
    // R6: capped at 3, released after 1st wait -> 2 waits
    run_cycle(1'b0, 1'b1, 1'b1, 3'b011, 1'b0, 1, w, t, s, p);
    chk(w == 2, "R6 capped release", w, 2);
    // R7: unlimited beyond any cap, released after 10 waits -> 11
    run_cycle(1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 10, w, t, s, p);
    chk(w == 11 && !t, "R7 long wait", w, 11);

    // R11: second start strobe during a busy boot cycle is ignored
    @(negedge clk);
    cfg_done = 1'b0; addr_internal = 1'b0; rdy_pin = 1'b0; rdy_pin_sel = 1'b1;
    repeat (4) @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    w = 0; s = 1'b0;
    for (int k = 0; k < 20; k++) begin
      cyc_start = (k == 0);
      if (cyc_done) begin s = 1'b1; break; end
      if (wait_en) w++;
      @(negedge clk);
    end
    cyc_start = 1'b0;
    chk(s && w == 3, "R11 busy start waits", w, 3);
    w = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (cyc_done || wait_en) w++;
    end
    chk(w == 0, "R11 no extra cycle", w, 0);

    // R11: count restarts; a following capped cycle still gets its full cap
    run_cycle(1'b0, 1'b1, 1'b1, 3'b010, 1'b0, -1, w, t, s, p);
    chk(w == 2, "R11 count restart", w, 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule